// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a software-programmable port of eight general-purpose pins. Each pin has three bits: a direction bit, a data bit and a synchronized input bit. Each kind of bit is grouped into one port-wide register, and each register has its own bus address. Software reaches the registers through a plain strobe bus made of an address, a write strobe, a read strobe, write data and read data.

Toward the pads the block drives three vectors, one bit per pin: an output level, an output enable and a pull-up enable. The data bit does two jobs. On an output pin it sets the level. On an input pin it turns on the pull-up. A port-wide pull-up-disable input overrides every pull-up.

The raw pad levels come back through a two-stage synchronizer clocked by the bus clock. While the sleep input is high, the synchronizer input of every input pin is held at 0. An asynchronous reset floats all pins, with no pull-up, even while the clock is stopped.

Top module: `gpio_port`

## Requirements
- R1: For each pin, `oe_o` equals its direction bit (1 = output, 0 = input), and `out_o` equals its data bit.
- R2: For each pin, `pu_o` is 1 only when the direction bit is 0, the data bit is 1 and `pud_i` is 0. In every other case it is 0.
- R3: While `pud_i` is 1, every bit of `pu_o` is 0, whatever the register contents.
- R4: Driving `rst_ni` low clears the direction register, the data register and the synchronizer at once, with no clock edge needed. After that, `oe_o`, `out_o` and `pu_o` are all 0.
- R5: With `sleep_i` low, a pad level sampled at one rising edge appears in the input register after the next rising edge, which makes two edges of latency.
- R6: With `sleep_i` high at the sampling edge, a pin whose direction bit is 0 enters the synchronizer as 0. A pin whose direction bit is 1 still samples its pad.
- R7: With `rd_i` high, `rdata_o` returns the direction register for address 0, the data register for address 1 and the synchronized input register for address 2. With address 3, or with `rd_i` low, `rdata_o` is 0.
- R8: A write strobe to address 2 inverts each data bit whose write-data bit is 1. The direction register and the other data bits are left unchanged.
- R9: A write to address 0 or 1 replaces only that register. A write to address 3 changes no register. The bits of one pin have no effect on any other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and synchronizer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select: 0 direction, 1 data, 2 input/toggle |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pad_i | input | 8 | Raw pad levels |
| pud_i | input | 1 | Port-wide pull-up disable |
| sleep_i | input | 1 | Sleep control, gates input pins into the synchronizer |
| out_o | output | 8 | Output level toward each pad |
| oe_o | output | 8 | Output enable toward each pad |
| pu_o | output | 8 | Pull-up enable toward each pad |

## Verification
The hardest case to reach is the sleep gating. The pad value that shows up must depend on the direction bits that were in force at the sampling edge, not at the read. The stimulus mixes input and output pins under sleep, and it changes the direction register in the same cycle that sleep is asserted. The second hard case is a reset taken while the clock is held still, with outputs and pull-ups active. The bench stops its own clock before it pulls reset low and checks the pad controls before any edge arrives. A cycle-by-cycle reference model with a queue standing in for the synchronizer covers random bus traffic and random pad levels around these directed cases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1,
    REG_IN   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] data_o
);
  logic [NUM_PINS-1:0] dir_q, data_q;
  reg_sel_e sel;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      case (sel)
        REG_DIR:  dir_q  <= wdata_i;
        REG_DATA: data_q <= wdata_i;
        REG_IN:   data_q <= data_q ^ wdata_i; // write-one-to-toggle
        default:  ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic                sleep_i,
  output logic [NUM_PINS-1:0] in_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [NUM_PINS-1:0] gated;
  logic [NUM_PINS-1:0] stage_q [STAGES];

  // input pins are held low in sleep so a floating pad stays quiet
  assign gated = sleep_i ? (pad_i & dir_i) : pad_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= gated;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign in_o = stage_q[LAST];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] data_i,
  input  logic                pud_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] pu_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign oe_o[p]  = dir_i[p];
    assign out_o[p] = data_i[p];
    assign pu_o[p]  = ~dir_i[p] & data_i[p] & ~pud_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic                pud_i,
  input  logic                sleep_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] pu_o
);
  logic [NUM_PINS-1:0] dir, data, in_sync;

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .dir_o  (dir),
    .data_o (data)
  );

  gpio_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .dir_i  (dir),
    .sleep_i(sleep_i),
    .in_o   (in_sync)
  );

  gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pad (
    .dir_i (dir),
    .data_i(data),
    .pud_i (pud_i),
    .out_o (out_o),
    .oe_o  (oe_o),
    .pu_o  (pu_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (reg_sel_e'(addr_i))
        REG_DIR:  rdata_o = dir;
        REG_DATA: rdata_o = data;
        REG_IN:   rdata_o = in_sync;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pad_i,
  input logic                pud_i,
  input logic                sleep_i,
  input logic [NUM_PINS-1:0] out_o,
  input logic [NUM_PINS-1:0] oe_o,
  input logic [NUM_PINS-1:0] pu_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_OE_FROM_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0) |=> (oe_o == $past(wdata_i))); // R1

  AST_NO_PU_ON_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pu_o & oe_o) == '0)); // R2

  AST_PUD_KILLS_PU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pud_i |-> (pu_o == '0)); // R3

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && rd_i && addr_i == 2'd2 && !$past(sleep_i, 2))
      |-> (rdata_o == $past(pad_i, 2))); // R5

  AST_TOGGLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2) |=> (out_o == ($past(out_o) ^ $past(wdata_i)))
      && $stable(oe_o)); // R8

  AST_DEAD_ADDR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd3) |=> ($stable(out_o) && $stable(oe_o))); // R9
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk = 1'b0;
  logic       clk_en = 1'b1;
  logic       rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, pad = '0;
  logic       pud = 1'b0, sleep = 1'b0;
  logic [7:0] rdata, out, oe, pu;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [7:0] m_dir = '0, m_data = '0;
  logic [7:0] m_q[$];

  always #4 if (clk_en) clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pud_i(pud),
    .sleep_i(sleep), .out_o(out), .oe_o(oe), .pu_o(pu)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_dir = '0; m_data = '0;
    m_q = {8'h00, 8'h00};
  endtask

  function automatic logic [7:0] exp_rdata();
    if (!rd) return '0;
    case (addr)
      2'd0: return m_dir;
      2'd1: return m_data;
      2'd2: return m_q[0];
      default: return '0;
    endcase
  endfunction

  task automatic compare();
    chk("R1 oe", oe, m_dir);
    chk("R1 out", out, m_data);
    chk("R2 pu", pu, pud ? 8'h00 : (~m_dir & m_data));
    chk("R7 rdata", rdata, exp_rdata());
  endtask

  task automatic model_update();
    logic [7:0] samp;
    logic [7:0] drop;
    samp = sleep ? (pad & m_dir) : pad;
    m_q.push_back(samp);
    drop = m_q.pop_front();
    if (wr) begin
      case (addr)
        2'd0: m_dir = wdata;
        2'd1: m_data = wdata;
        2'd2: m_data = m_data ^ wdata;
        default: ;
      endcase
    end
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, string tag, logic [7:0] exp);
    rd = 1'b1; addr = a; #1;
    chk(tag, rdata, exp);
    tick();
    rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    #2;
    // R4 reset state
    chk("R4 oe reset", oe, 8'h00);
    chk("R4 pu reset", pu, 8'h00);
    chk("R4 out reset", out, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    tick();

    // R1 / R2 mixed directions
    bus_write(2'd0, 8'h0F);
    bus_write(2'd1, 8'h35);
    #1;
    chk("R1 oe mix", oe, 8'h0F);
    chk("R2 pu mix", pu, 8'h30);
    tick();

    // R3 global pull-up disable
    pud = 1'b1; #1;
    chk("R3 pud off", pu, 8'h00);
    tick();
    pud = 1'b0; tick();

    // R5 two-edge latency
    bus_write(2'd0, 8'h00);
    pad = 8'hA5; rd = 1'b1; addr = 2'd2;
    tick();
    chk("R5 after one edge", rdata, 8'h00);
    tick();
    chk("R5 after two edges", rdata, 8'hA5);
    rd = 1'b0;

    // R6 sleep gating: dir changes in the same cycle sleep rises
    pad = 8'hFF; sleep = 1'b1;
    bus_write(2'd0, 8'h0F);
    tick(); tick();
    bus_read(2'd2, "R6 sleep mix", 8'h0F);
    sleep = 1'b0; tick(); tick();
    bus_read(2'd2, "R6 wake", 8'hFF);

    // R8 toggle
    bus_write(2'd1, 8'h35);
    bus_write(2'd2, 8'hF0);
    bus_read(2'd1, "R8 toggle data", 8'hC5);
    bus_read(2'd0, "R8 dir kept", 8'h0F);

    // R9 dead address and per-register isolation
    bus_write(2'd3, 8'hFF);
    bus_read(2'd0, "R9 dir after addr3", 8'h0F);
    bus_read(2'd1, "R9 data after addr3", 8'hC5);
    bus_write(2'd0, 8'h10);
    bus_read(2'd1, "R9 data after dir write", 8'hC5);
    bus_read(2'd3, "R7 addr3 read", 8'h00);
    rd = 1'b0; addr = 2'd0; #1;
    chk("R7 rd low", rdata, 8'h00);
    tick();

    // random traffic
    for (int i = 0; i < 400; i++) begin
      wr = $urandom_range(0, 1) == 1;
      rd = $urandom_range(0, 1) == 1;
      addr = 2'($urandom_range(0, 3));
      wdata = 8'($urandom);
      pad = 8'($urandom);
      pud = $urandom_range(0, 3) == 0;
      sleep = $urandom_range(0, 3) == 0;
      tick();
    end
    wr = 1'b0; rd = 1'b0; pud = 1'b0; sleep = 1'b0;
    bus_write(2'd0, 8'hF0);
    bus_write(2'd1, 8'h3C);

    // R4 asynchronous reset with clock stopped
    clk_en = 1'b0;
    #3;
    rst_ni = 1'b0;
    #1;
    chk("R4 async oe", oe, 8'h00);
    chk("R4 async pu", pu, 8'h00);
    chk("R4 async out", out, 8'h00);
    model_reset();
    #5;
    rst_ni = 1'b1;
    clk_en = 1'b1;
    @(negedge clk);
    rd = 1'b1; addr = 2'd2; #1;
    chk("R4 sync cleared", rdata, 8'h00);
    rd = 1'b0;
    tick(); tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule